// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programmable state of a four-channel DMA engine: for every channel a 16-bit memory address and a 14-bit transfer counter, plus a shared 8-bit mode register and an 8-bit status register. A host processor reaches all of it through a narrow slave port: a chip select, read and write strobes, a 4-bit register address and an 8-bit data bus. Because the port is one byte wide, each 16-bit register is reached a byte at a time. A single byte-pointer flip-flop, shared by all channel registers, picks the byte.

The transfer sequencer drives one advance pulse per channel for each completed transfer. On every advance of an enabled channel, the channel's address steps up by one and its counter steps down by one. In the same cycle the block reports a terminal-count event and, every 128 transfers, a mark event. The status register collects the terminal-count events until the host reads it. A stop-on-terminal-count option turns a finished channel off. An auto-load option refills channel 2 from channel 3 in a one-cycle update phase, so that channel 2 can run repeated blocks. Bus tristating and transfer timing are handled outside this block.

Top module: `dma_chreg_top`

## Requirements
- R1: After reset all channel addresses and counts are 0, the mode register is 0 (every channel disabled), the status register reads 0, the byte pointer selects the low byte, `upd_o` is 0, and `rdata_o` is 0 whenever no read is in progress.
- R2: Register address 2n holds channel n's address and 2n+1 its count (n = 0..3). Each read or write of addresses 0 to 7 accesses the low byte when the byte pointer is 0 and the high byte when it is 1. The pointer then toggles.
- R3: A write to address 8 loads the mode register and clears the byte pointer. `mode_o` shows the mode register with this layout: bit 7 auto-load, bit 6 stop-on-terminal-count, bit 5 extended write, bit 4 rotating priority, bits 3..0 enables of channels 3..0.
- R4: A high-byte write to a count register stores only data bits 5..0. A high-byte read of a count returns bits 7..6 as 0.
- R5: An advance pulse on an enabled channel adds 1 to its address (wrapping in 16 bits) and subtracts 1 from its count (wrapping in 14 bits) at the next clock edge. An advance pulse on a disabled channel has no effect.
- R6: `tc_o[n]` is 1 in the cycle in which `adv_i[n]` is 1, channel n is enabled, and its count is 0.
- R7: `mark_o[n]` is 1 in the cycle in which `adv_i[n]` is 1, channel n is enabled, and the low 7 bits of its count are 0. A mark therefore occurs every 128 transfers, counted back from the terminal transfer.
- R8: A read of address 8 returns {3'b000, update flag, TC3, TC2, TC1, TC0}. A channel's TC bit is set by its terminal-count event. A status read clears all TC bits at the end of the read, except for a bit whose terminal-count event falls in the same cycle.
- R9: When stop-on-terminal-count is set, a channel's enable bit is cleared at its terminal-count event. The exception is channel 2 while auto-load is set.
- R10: With auto-load set, a terminal count on channel 2 raises the update flag (`upd_o` and status bit 4) for exactly the next cycle. At the end of that cycle channel 3's address and count are copied into channel 2, and channel 2 stays enabled.
- R11: Writes to addresses 9 to 15 change nothing, including the byte pointer. Reads of addresses 9 to 15 return 0, and `rdata_o` is 0 when chip select or read is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select for the host port |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| reg_addr_i | input | 4 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid during the read cycle |
| adv_i | input | 4 | Per-channel transfer advance pulse from the sequencer |
| chan_addr_o | output | 64 | Current addresses, channel n in bits 16n+15..16n |
| mode_o | output | 8 | Mode register contents |
| tc_o | output | 4 | Terminal-count event per channel |
| mark_o | output | 4 | 128-transfer mark event per channel |
| upd_o | output | 1 | Auto-load update phase in progress |

## Verification
The assertions assume a well-behaved host and sequencer:
- Read and write are never asserted together.
- A host write to a channel register never coincides with an advance of that channel or with the auto-load update cycle, because the write would take priority and the advance would be lost.
- At most one channel advances per cycle.

The stimulus follows these rules. It issues single host accesses back to back and drives advance pulses only when no host access is pending. It also never advances channel 2 during its update cycle.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int NCH      = 4;   // channels
  localparam int AW       = 16;  // address register width
  localparam int CW       = 14;  // counter width
  localparam int MARK_W   = 7;   // mark period = 2**MARK_W transfers
  localparam int RA_W     = 4;   // host register address width
  localparam int AUTO_CH  = 2;   // channel refilled in auto-load
  localparam int AUTO_SRC = 3;   // channel that supplies the refill

  typedef struct packed {
    logic           autoload;
    logic           stop_tc;
    logic           ext_wr;
    logic           rot_prio;
    logic [NCH-1:0] en;
  } mode_t;

  function automatic logic [7:0] byte_pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/dmarf_chan.sv
module dmarf_chan #(
  parameter int AW     = 16,
  parameter int CW     = 14,
  parameter int MARK_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr_lo,
  input  logic          wr_addr_hi,
  input  logic          wr_cnt_lo,
  input  logic          wr_cnt_hi,
  input  logic [7:0]    wdata,
  input  logic          step,
  input  logic          reload,
  input  logic [AW-1:0] reload_addr,
  input  logic [CW-1:0] reload_cnt,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          tc_evt,
  output logic          mark_evt
);
  localparam int AHI = AW - 8;
  localparam int CHI = CW - 8;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c - {{(CW-1){1'b0}}, 1'b1};
  endfunction

  logic wr_any;
  assign wr_any   = wr_addr_lo | wr_addr_hi | wr_cnt_lo | wr_cnt_hi;
  assign tc_evt   = step && (cnt_q == '0);
  assign mark_evt = step && (cnt_q[MARK_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (wr_addr_lo) begin
      addr_q[7:0] <= wdata;
    end else if (wr_addr_hi) begin
      addr_q[AW-1:8] <= wdata[AHI-1:0];
    end else if (wr_cnt_lo) begin
      cnt_q[7:0] <= wdata;
    end else if (wr_cnt_hi) begin
      cnt_q[CW-1:8] <= wdata[CHI-1:0];
    end else if (reload) begin
      addr_q <= reload_addr;
      cnt_q  <= reload_cnt;
    end else if (step) begin
      addr_q <= addr_next(addr_q);
      cnt_q  <= cnt_next(cnt_q);
    end
  end

  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_any && !reload) |=>
      (addr_q == addr_next($past(addr_q)) && cnt_q == cnt_next($past(cnt_q))));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_any && !reload) |=> ($stable(addr_q) && $stable(cnt_q)));

  // R7
  tc_has_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |-> mark_evt);
endmodule

// File: rtl/dmarf_ctrl.sv
module dmarf_ctrl
  import dmarf_pkg::*;
#(
  parameter int N = dmarf_pkg::NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_chan,
  input  logic         mode_wr,
  input  logic         stat_rd,
  input  logic [7:0]   wdata,
  input  logic [N-1:0] tc_evt,
  output mode_t        mode_q,
  output logic [N-1:0] tc_flags,
  output logic         upd_q,
  output logic         ptr_q
);
  logic [N-1:0] keep;
  assign keep = mode_q.autoload ? N'(1 << AUTO_CH) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_t'(wdata);
    end else if (mode_q.stop_tc) begin
      mode_q.en <= mode_q.en & ~(tc_evt & ~keep);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tc_flags <= '0;
    else if (stat_rd) tc_flags <= tc_evt;
    else              tc_flags <= tc_flags | tc_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                upd_q <= 1'b0;
    else if (upd_q)                            upd_q <= 1'b0;
    else if (mode_q.autoload && tc_evt[AUTO_CH]) upd_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= 1'b0;
    else if (mode_wr)  ptr_q <= 1'b0;
    else if (acc_chan) ptr_q <= ~ptr_q;
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !ptr_q);

  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_chan && !mode_wr) |=> (ptr_q != $past(ptr_q)));

  // R8
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_evt) |=> ((tc_flags & $past(tc_evt)) == $past(tc_evt)));

  // R10
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && mode_q.stop_tc && (|tc_evt)) |=>
      ((mode_q.en & $past(tc_evt & ~keep)) == '0));
endmodule

// File: rtl/dma_chreg_top.sv
module dma_chreg_top
  import dmarf_pkg::*;
#(
  parameter int AW     = dmarf_pkg::AW,
  parameter int CW     = dmarf_pkg::CW,
  parameter int MARK_W = dmarf_pkg::MARK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [NCH-1:0]    adv_i,
  output logic [NCH*AW-1:0] chan_addr_o,
  output logic [7:0]        mode_o,
  output logic [NCH-1:0]    tc_o,
  output logic [NCH-1:0]    mark_o,
  output logic              upd_o
);
  localparam int CH_BITS   = $clog2(NCH);
  localparam int STAT_ADDR = 2 * NCH;

  mode_t           mode;
  logic [NCH-1:0]  tc_flags, tc_evt, mark_evt;
  logic            upd, ptr;
  logic [AW-1:0]   addr_arr [NCH];
  logic [CW-1:0]   cnt_arr  [NCH];

  logic            is_chan, acc_chan, wr_chan, mode_wr, stat_rd;
  logic [CH_BITS-1:0] sel_ch;

  assign is_chan  = !reg_addr_i[RA_W-1];
  assign sel_ch   = reg_addr_i[CH_BITS:1];
  assign acc_chan = cs_i && (rd_i || wr_i) && is_chan;
  assign wr_chan  = cs_i && wr_i && is_chan;
  assign mode_wr  = cs_i && wr_i && (reg_addr_i == RA_W'(STAT_ADDR));
  assign stat_rd  = cs_i && rd_i && (reg_addr_i == RA_W'(STAT_ADDR));

  dmarf_ctrl #(.N(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_chan(acc_chan), .mode_wr(mode_wr),
    .stat_rd(stat_rd), .wdata(wdata_i), .tc_evt(tc_evt), .mode_q(mode),
    .tc_flags(tc_flags), .upd_q(upd), .ptr_q(ptr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          hit, rl;
    logic [AW-1:0] rl_addr;
    logic [CW-1:0] rl_cnt;

    assign hit = wr_chan && (sel_ch == CH_BITS'(g));

    if (g == AUTO_CH) begin : g_auto
      assign rl      = upd;
      assign rl_addr = addr_arr[AUTO_SRC];
      assign rl_cnt  = cnt_arr[AUTO_SRC];
    end else begin : g_plain
      assign rl      = 1'b0;
      assign rl_addr = '0;
      assign rl_cnt  = '0;
    end

    dmarf_chan #(.AW(AW), .CW(CW), .MARK_W(MARK_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_addr_lo(hit && !reg_addr_i[0] && !ptr),
      .wr_addr_hi(hit && !reg_addr_i[0] &&  ptr),
      .wr_cnt_lo (hit &&  reg_addr_i[0] && !ptr),
      .wr_cnt_hi (hit &&  reg_addr_i[0] &&  ptr),
      .wdata(wdata_i), .step(adv_i[g] && mode.en[g]),
      .reload(rl), .reload_addr(rl_addr), .reload_cnt(rl_cnt),
      .addr_q(addr_arr[g]), .cnt_q(cnt_arr[g]),
      .tc_evt(tc_evt[g]), .mark_evt(mark_evt[g])
    );

    assign chan_addr_o[g*AW +: AW] = addr_arr[g];
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      if (is_chan) begin
        if (reg_addr_i[0]) rdata_o = byte_pick({{(16-CW){1'b0}}, cnt_arr[sel_ch]}, ptr);
        else               rdata_o = byte_pick(addr_arr[sel_ch], ptr);
      end else if (reg_addr_i == RA_W'(STAT_ADDR)) begin
        rdata_o = {{(7-NCH){1'b0}}, upd, tc_flags};
      end
    end
  end

  assign mode_o = mode;
  assign tc_o   = tc_evt;
  assign mark_o = mark_evt;
  assign upd_o  = upd;

  // R6
  tc_needs_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_o & ~adv_i) == '0));

  // R11
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && wr_i && !rd_i && reg_addr_i > RA_W'(STAT_ADDR) && adv_i == '0) |=>
      ($stable(mode_o) && $stable(chan_addr_o)));
endmodule

// File: tb/dma_chreg_top_tb_top.sv
module dma_chreg_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_i = 0, rd_i = 0, wr_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [3:0]  adv_i = '0;
  logic [63:0] chan_addr_o;
  logic [7:0]  mode_o;
  logic [3:0]  tc_o, mark_o;
  logic        upd_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chreg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .reg_addr_i(reg_addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .adv_i(adv_i), .chan_addr_o(chan_addr_o), .mode_o(mode_o),
    .tc_o(tc_o), .mark_o(mark_o), .upd_o(upd_o)
  );

  typedef struct { string req; logic [7:0] val; bit is_adv; } exp_t;
  exp_t sbq[$];
  exp_t cur;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  logic [15:0] m_addr [4];
  logic [13:0] m_cnt  [4];
  logic [7:0]  m_mode;
  logic [3:0]  m_tc;
  logic        m_ptr, m_upd;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_flat();
    return {m_addr[3], m_addr[2], m_addr[1], m_addr[0]};
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [15:0] w;
    if (a < 4'd8) begin
      w = a[0] ? {2'b00, m_cnt[a[2:1]]} : m_addr[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'd8) return {3'b000, m_upd, m_tc};
    return 8'h00;
  endfunction

  // all driver tasks start and end on a falling edge
  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    cs_i = 1; wr_i = 1; reg_addr_i = a; wdata_i = d;
    if (a < 4'd8) begin
      if (!a[0]) begin
        if (m_ptr) m_addr[a[2:1]][15:8] = d; else m_addr[a[2:1]][7:0] = d;
      end else begin
        if (m_ptr) m_cnt[a[2:1]][13:8] = d[5:0]; else m_cnt[a[2:1]][7:0] = d;
      end
      m_ptr = ~m_ptr;
    end else if (a == 4'd8) begin
      m_mode = d; m_ptr = 1'b0;
    end
    @(negedge clk);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic cpu_rd(input logic [3:0] a, input string req);
    exp_t e;
    cs_i = 1; rd_i = 1; reg_addr_i = a;
    e.req = req; e.val = m_read(a); e.is_adv = 0;
    sbq.push_back(e);
    if (a < 4'd8) m_ptr = ~m_ptr;
    else if (a == 4'd8) m_tc = '0;
    @(negedge clk);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic adv(input int ch, input string req);
    exp_t e;
    logic tc, mk;
    adv_i = 4'(1 << ch);
    tc = 0; mk = 0;
    if (m_mode[ch]) begin
      tc = (m_cnt[ch] == 14'd0);
      mk = (m_cnt[ch][6:0] == 7'd0);
      m_addr[ch] = m_addr[ch] + 16'd1;
      m_cnt[ch]  = m_cnt[ch] - 14'd1;
      if (tc) begin
        m_tc[ch] = 1'b1;
        if (m_mode[7] && ch == 2) m_upd = 1'b1;
        else if (m_mode[6]) m_mode[ch] = 1'b0;
      end
    end
    e.req = req; e.is_adv = 1;
    e.val = {4'(tc << ch), 4'(mk << ch)};
    sbq.push_back(e);
    @(negedge clk);
    adv_i = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && ((cs_i && rd_i) || (|adv_i))) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: result with no expected item, actual=%h expected=none", rdata_o);
      end else begin
        cur = sbq.pop_front();
        if (cur.is_adv) chk(cur.req, {56'd0, tc_o, mark_o}, {56'd0, cur.val});
        else            chk(cur.req, {56'd0, rdata_o}, {56'd0, cur.val});
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; end
    m_mode = '0; m_tc = '0; m_ptr = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1", chan_addr_o, 64'd0);
    chk("R1", {56'd0, mode_o}, 64'd0);
    chk("R1", {63'd0, upd_o}, 64'd0);
    chk("R1", {56'd0, rdata_o}, 64'd0);
    cpu_rd(4'd8, "R1");
    cpu_rd(4'd1, "R1");

    // R3 mode write clears the pointer; R2 / R4 programming
    cpu_wr(4'd8, 8'h00);
    cpu_wr(4'd0, 8'hFF); cpu_wr(4'd0, 8'h12);
    cpu_wr(4'd1, 8'h02); cpu_wr(4'd1, 8'hC0);
    cpu_wr(4'd2, 8'hCD); cpu_wr(4'd2, 8'hAB);
    cpu_wr(4'd3, 8'h81); cpu_wr(4'd3, 8'h00);
    cpu_rd(4'd0, "R2"); cpu_rd(4'd0, "R2");
    cpu_rd(4'd1, "R4"); cpu_rd(4'd1, "R4");
    cpu_rd(4'd2, "R2"); cpu_rd(4'd2, "R2");
    chk("R2", chan_addr_o, m_flat());

    // R3: leave pointer on high byte, then mode write realigns it
    cpu_wr(4'd4, 8'h34);
    cpu_wr(4'd8, 8'h35);
    chk("R3", {56'd0, mode_o}, 64'h35);
    cpu_wr(4'd4, 8'h56); cpu_wr(4'd4, 8'h20);
    cpu_rd(4'd4, "R3"); cpu_rd(4'd4, "R3");
    cpu_wr(4'd5, 8'h00); cpu_wr(4'd5, 8'h00);

    // R5: advance on disabled channel 1 is ignored
    adv(1, "R5");
    chk("R5", chan_addr_o, m_flat());

    // R6 / R9: stop-on-TC, channel 0 count 2 -> terminal on third advance
    cpu_wr(4'd8, 8'h4F);
    adv(0, "R6"); adv(0, "R6"); adv(0, "R6");
    chk("R5", chan_addr_o, m_flat());
    chk("R9", {56'd0, mode_o}, {56'd0, m_mode});
    cpu_rd(4'd1, "R5"); cpu_rd(4'd1, "R5");

    // R7: channel 1 count 0x81 -> mark on second advance
    adv(1, "R7"); adv(1, "R7");

    // R8: status shows TC0 then clears
    cpu_rd(4'd8, "R8");
    cpu_rd(4'd8, "R8");

    // R10: auto-load refill of channel 2 from channel 3
    cpu_wr(4'd8, 8'h00);
    cpu_wr(4'd6, 8'h00); cpu_wr(4'd6, 8'h40);
    cpu_wr(4'd7, 8'h05); cpu_wr(4'd7, 8'h00);
    cpu_wr(4'd8, 8'hCC);
    adv(2, "R10");
    chk("R10", {63'd0, upd_o}, 64'd1);
    cpu_rd(4'd8, "R10");
    m_upd = 0; m_addr[2] = m_addr[3]; m_cnt[2] = m_cnt[3];
    chk("R10", {63'd0, upd_o}, 64'd0);
    chk("R10", chan_addr_o, m_flat());
    chk("R10", {56'd0, mode_o}, 64'hCC);
    cpu_rd(4'd5, "R10");
    cpu_rd(4'd8, "R8");

    // R11: unused addresses and idle read data
    cpu_wr(4'd9, 8'hFF); cpu_wr(4'hF, 8'hAA);
    chk("R11", {56'd0, mode_o}, 64'hCC);
    cpu_rd(4'd9, "R11"); cpu_rd(4'hF, "R11");
    cpu_rd(4'd5, "R11");
    cs_i = 0; rd_i = 1; reg_addr_i = 4'd0;
    #1 chk("R11", {56'd0, rdata_o}, 64'd0);
    @(negedge clk);
    rd_i = 0;

    @(negedge clk);
    if (sbq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d items left, actual=%0d expected=0", sbq.size(), sbq.size());
    end
    finish_run();
  end
endmodule